// File: doc/BRIEF.md
# Two-Window RAM Bank Mapper

This block is the address glue between an 8-bit processor with a 16-bit address bus and a 512 KiB RAM that is organised as sixteen 32 KiB pages. It holds two 4-bit page registers. The top CPU address bit picks which of them supplies physical address bits 18:15. The lower half of the CPU map therefore looks through one page window and the upper half through a second one. Software can copy between any two pages without reloading either register between accesses.

The lowest 2 KiB of the CPU map is carved out of banking. It always reaches the first 2 KiB of physical RAM, so the stack and zero page never move. A 4 KiB ROM at the top of the map holds the reset and interrupt vectors, and it overrides banked RAM. A single 256-byte I/O page is split into eight 32-byte sub-selects: the two page registers, an SPI port, an output byte and an input byte, with three spare. The address decode is purely combinational. Only the page registers are clocked, and they are committed when the phase-2 strobe falls at the end of a write cycle.

Top module: `bankmap_top`

## Requirements
- R1: For CPU addresses $0800–$7FFF outside ROM and I/O, ram_addr is {page register 0, cpu_addr[14:0]}.
- R2: For CPU addresses $8000–$EEFF, ram_addr is {page register 1, cpu_addr[14:0]}.
- R3: For CPU addresses $0000–$07FF, ram_addr equals cpu_addr (physical $00000–$007FF) whatever page register 0 holds.
- R4: Addresses $F000–$FFFF assert rom_cs while phi2 is high and never assert ram_cs. A write there changes neither page register.
- R5: Addresses $EF00–$EFFF select I/O and never RAM. While phi2 is high, io_sel bit n is the only bit set, where n = cpu_addr[7:5]. Bit 0 is page register 0, bit 1 is page register 1, bit 2 is the SPI port, bit 3 is the output byte and bit 4 is the input byte.
- R6: A write (cpu_wr high while phi2 is high) to sub-select 0 or 1 loads cpu_wdata[3:0] into that page register. The old value stays in use until the first clk edge at which phi2 is sampled low, and the new value is in use after that edge.
- R7: cpu_rdata is {4'b0, page register} while cpu_addr lies in sub-select 0 or 1, and 0 for any other address.
- R8: A synchronous active-high rst clears both page registers to 0.
- R9: ram_cs, rom_cs and io_sel are all low while phi2 is low. ram_we is high only when ram_cs and cpu_wr are both high.
- R10: Every decode output follows cpu_addr within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bus phase |
| rst | input | 1 | Synchronous active-high reset |
| phi2 | input | 1 | Bus phase-2 strobe, high during the data part of a cycle |
| cpu_addr | input | 16 | CPU address |
| cpu_wr | input | 1 | High for a CPU write cycle |
| cpu_wdata | input | 8 | CPU write data |
| cpu_rdata | output | 8 | Page-register readback, zero outside its sub-selects |
| ram_addr | output | 19 | Physical RAM address |
| ram_cs | output | 1 | RAM chip select |
| ram_we | output | 1 | RAM write enable |
| rom_cs | output | 1 | ROM chip select |
| io_sel | output | 8 | One-hot I/O sub-selects |

## Verification
The chip selects, ram_addr and cpu_rdata are due with no latency. The bench checks them one time step after it drives a new address, before any clock edge, and checks them again one edge later. A page-register write is due one clk edge after phi2 is sampled low. The bench checks ram_addr in the gap between the fall of phi2 and that edge, where the old page is still expected. It moves its reference model to the new value only at the next falling clock edge and checks again there. Random bus cycles, weighted toward the I/O page, are mixed with directed writes to ROM, the spare sub-selects, the 2 KiB boundary and a mid-run reset.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  // sub-select numbers inside the I/O page (address bits 7:5)
  localparam int SUB_PAGE0 = 0;
  localparam int SUB_PAGE1 = 1;
  localparam int SUB_SPI   = 2;
  localparam int SUB_OUTB  = 3;
  localparam int SUB_INB   = 4;

  // which device a CPU address falls on; at most one bit set
  typedef struct packed {
    logic ram;
    logic rom;
    logic io;
  } region_t;
endpackage

// File: rtl/bankmap_decode.sv
module bankmap_decode
  import bankmap_pkg::*;
#(
  parameter int CPU_AW   = 16,
  parameter int WIN_AW   = 15,
  parameter int FIX_AW   = 11,
  parameter int ROM_W    = 4,
  parameter logic [ROM_W-1:0] ROM_TAG = 4'hF,
  parameter int IO_OFF_W = 8,
  parameter logic [CPU_AW-IO_OFF_W-1:0] IO_TAG = 8'hEF,
  parameter int SUB_W    = 3,
  localparam int SEL_W   = CPU_AW - WIN_AW,
  localparam int NSUB    = 2 ** SUB_W
) (
  input  logic [CPU_AW-1:0] addr,
  output region_t           region,
  output logic              fixed_low,
  output logic [SEL_W-1:0]  win_sel,
  output logic [SUB_W-1:0]  sub_idx,
  output logic [NSUB-1:0]   sub_hit
);
  logic rom_hit, io_hit;
  logic unused_lo;

  assign rom_hit   = (addr[CPU_AW-1 -: ROM_W] == ROM_TAG);
  assign io_hit    = (addr[CPU_AW-1:IO_OFF_W] == IO_TAG);
  assign fixed_low = (addr[CPU_AW-1:FIX_AW] == '0);
  assign win_sel   = addr[CPU_AW-1:WIN_AW];
  assign sub_idx   = addr[IO_OFF_W-1 -: SUB_W];
  assign unused_lo = ^addr[IO_OFF_W-SUB_W-1:0];

  // ROM wins over everything, then the I/O page, then RAM
  always_comb begin
    region     = '0;
    region.rom = rom_hit;
    region.io  = io_hit && !rom_hit;
    region.ram = !io_hit && !rom_hit;
  end

  for (genvar s = 0; s < NSUB; s++) begin : g_sub
    assign sub_hit[s] = region.io && (sub_idx == SUB_W'(s));
  end
endmodule

// File: rtl/bankmap_regs.sv
module bankmap_regs #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 4,
  localparam int IDX_W    = $clog2(NUM_BANKS)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              phi2,
  input  logic                              wr_req,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [BANK_W-1:0]                 wr_data,
  output logic [NUM_BANKS-1:0][BANK_W-1:0]  banks
);
  logic              phi2_q;
  logic              pend_wr;
  logic [IDX_W-1:0]  pend_idx;
  logic [BANK_W-1:0] pend_data;
  logic              commit;

  // track the request while phi2 is high; the last sample before the fall wins
  always_ff @(posedge clk) begin
    if (rst) begin
      phi2_q    <= 1'b0;
      pend_wr   <= 1'b0;
      pend_idx  <= '0;
      pend_data <= '0;
    end else begin
      phi2_q <= phi2;
      if (phi2) begin
        pend_wr   <= wr_req;
        pend_idx  <= wr_idx;
        pend_data <= wr_data;
      end else if (phi2_q) begin
        pend_wr   <= 1'b0;
      end
    end
  end

  assign commit = phi2_q && !phi2 && pend_wr;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic [BANK_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                   q <= '0;
      else if (commit && pend_idx == IDX_W'(b))  q <= pend_data;
    end
    assign banks[b] = q;
  end

  // R6: page registers only move at the commit following a phi2 fall
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !(phi2_q && !phi2) |=> $stable(banks));
  // R8: reset leaves every page register at zero
  p_clear_r8: assert property (@(posedge clk) rst |=> (banks == '0));
endmodule

// File: rtl/bankmap_top.sv
module bankmap_top
  import bankmap_pkg::*;
#(
  parameter int CPU_AW = 16,
  parameter int DATA_W = 8,
  parameter int BANK_W = 4,
  parameter int WIN_AW = 15,
  parameter int FIX_AW = 11,
  parameter int SUB_W  = 3,
  localparam int PHYS_AW   = BANK_W + WIN_AW,
  localparam int NUM_BANKS = 2 ** (CPU_AW - WIN_AW),
  localparam int IDX_W     = $clog2(NUM_BANKS),
  localparam int NSUB      = 2 ** SUB_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               phi2,
  input  logic [CPU_AW-1:0]  cpu_addr,
  input  logic               cpu_wr,
  input  logic [DATA_W-1:0]  cpu_wdata,
  output logic [DATA_W-1:0]  cpu_rdata,
  output logic [PHYS_AW-1:0] ram_addr,
  output logic               ram_cs,
  output logic               ram_we,
  output logic               rom_cs,
  output logic [NSUB-1:0]    io_sel
);
  region_t                         region;
  logic                            fixed_low;
  logic [IDX_W-1:0]                win_sel;
  logic [SUB_W-1:0]                sub_idx;
  logic [NSUB-1:0]                 sub_hit;
  logic [NUM_BANKS-1:0][BANK_W-1:0] banks;
  logic                            page_reg_hit;
  logic [IDX_W-1:0]                reg_idx;
  logic                            unused_wd;

  bankmap_decode #(
    .CPU_AW(CPU_AW), .WIN_AW(WIN_AW), .FIX_AW(FIX_AW), .SUB_W(SUB_W)
  ) u_decode (
    .addr(cpu_addr), .region(region), .fixed_low(fixed_low),
    .win_sel(win_sel), .sub_idx(sub_idx), .sub_hit(sub_hit)
  );

  assign page_reg_hit = region.io && (sub_idx < SUB_W'(NUM_BANKS));
  assign reg_idx      = sub_idx[IDX_W-1:0];
  assign unused_wd    = ^cpu_wdata[DATA_W-1:BANK_W];

  bankmap_regs #(.NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W)) u_regs (
    .clk(clk), .rst(rst), .phi2(phi2),
    .wr_req(phi2 && cpu_wr && page_reg_hit),
    .wr_idx(reg_idx), .wr_data(cpu_wdata[BANK_W-1:0]),
    .banks(banks)
  );

  // physical address: carve-out bypasses the page registers
  always_comb begin
    if (fixed_low) ram_addr = {{BANK_W{1'b0}}, cpu_addr[WIN_AW-1:0]};
    else           ram_addr = {banks[win_sel], cpu_addr[WIN_AW-1:0]};
  end

  assign ram_cs    = phi2 && region.ram;
  assign ram_we    = ram_cs && cpu_wr;
  assign rom_cs    = phi2 && region.rom;
  assign io_sel    = phi2 ? sub_hit : '0;
  assign cpu_rdata = page_reg_hit ? {{(DATA_W-BANK_W){1'b0}}, banks[reg_idx]} : '0;

  // R5: never more than one device selected
  p_one_dev_r5: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ram_cs, rom_cs, |io_sel}));
  // R4: vector area is ROM only
  p_vec_rom_r4: assert property (@(posedge clk) disable iff (rst)
    (phi2 && cpu_addr >= 16'hFFFA) |-> (rom_cs && !ram_cs));
  // R3: carve-out stays in the first 2 KiB of RAM
  p_low_fixed_r3: assert property (@(posedge clk) disable iff (rst)
    (ram_cs && cpu_addr < 16'h0800) |-> (ram_addr[PHYS_AW-1:FIX_AW] == '0));
  // R9: no select outside phase 2, write enable tied to a RAM write
  p_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !phi2 |-> (!ram_cs && !rom_cs && io_sel == '0));
  p_we_r9: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> (ram_cs && cpu_wr));
endmodule

// File: tb/bankmap_top_bench.sv
module bankmap_top_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        phi2 = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [7:0]  cpu_wdata = '0;
  logic [7:0]  cpu_rdata;
  logic [18:0] ram_addr;
  logic        ram_cs, ram_we, rom_cs;
  logic [7:0]  io_sel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] m_p0 = '0, m_p1 = '0;

  always #4 clk = ~clk;

  bankmap_top u_bankmap_top (
    .clk(clk), .rst(rst), .phi2(phi2), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .ram_addr(ram_addr),
    .ram_cs(ram_cs), .ram_we(ram_we), .rom_cs(rom_cs), .io_sel(io_sel)
  );

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h addr=%04h", req, what, act, exp, cpu_addr);
    end
  endtask

  function automatic bit is_rom(logic [15:0] a); return a >= 16'hF000; endfunction
  function automatic bit is_io(logic [15:0] a); return a[15:8] == 8'hEF; endfunction
  function automatic bit is_ram(logic [15:0] a); return !is_rom(a) && !is_io(a); endfunction
  function automatic logic [18:0] exp_ram(logic [15:0] a);
    if (a < 16'h0800) return {4'h0, a[14:0]};
    return {(a[15] ? m_p1 : m_p0), a[14:0]};
  endfunction
  function automatic logic [7:0] exp_rd(logic [15:0] a);
    if (is_io(a) && a[7:5] == 3'd0) return {4'h0, m_p0};
    if (is_io(a) && a[7:5] == 3'd1) return {4'h0, m_p1};
    return 8'h00;
  endfunction
  function automatic string ram_tag(logic [15:0] a);
    if (a < 16'h0800) return "R3";
    return a[15] ? "R2" : "R1";
  endfunction

  task automatic check_live(string why);
    chk(ram_tag(cpu_addr), {why, " ram_addr"}, 32'(ram_addr), 32'(exp_ram(cpu_addr)));
    chk("R7", {why, " rdata"}, 32'(cpu_rdata), 32'(exp_rd(cpu_addr)));
    chk("R4", {why, " rom_cs"}, 32'(rom_cs), 32'(phi2 && is_rom(cpu_addr)));
    chk("R5", {why, " io_sel"}, 32'(io_sel), (phi2 && is_io(cpu_addr)) ? 32'(8'h01 << cpu_addr[7:5]) : 32'h0);
    chk("R9", {why, " ram_cs"}, 32'(ram_cs), 32'(phi2 && is_ram(cpu_addr)));
    chk("R9", {why, " ram_we"}, 32'(ram_we), 32'(phi2 && is_ram(cpu_addr) && cpu_wr));
  endtask

  // one bus cycle: phi2 high for two clk periods, then low
  task automatic bus(logic [15:0] a, logic wr, logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wr = wr; cpu_wdata = d; phi2 = 1'b1;
    #1 check_live("R10 same-cycle");
    @(negedge clk);
    check_live("phase2");
    @(negedge clk);
    phi2 = 1'b0;
    #1;
    check_live("R6 before commit");
    @(negedge clk);
    if (wr && is_io(a) && a[7:5] == 3'd0) m_p0 = d[3:0];
    if (wr && is_io(a) && a[7:5] == 3'd1) m_p1 = d[3:0];
    check_live("R6 after commit");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; phi2 = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_p0 = '0; m_p1 = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    do_reset();
    // R8: both page registers read back zero
    cpu_addr = 16'hEF00; #1 chk("R8", "page0 after reset", 32'(cpu_rdata), 32'h0);
    cpu_addr = 16'hEF20; #1 chk("R8", "page1 after reset", 32'(cpu_rdata), 32'h0);
    cpu_addr = 16'h8123; #1 chk("R8", "ram_addr after reset", 32'(ram_addr), 32'h00123);

    bus(16'hEF00, 1'b1, 8'hF5);   // page0 = 5, upper data bits dropped (R6)
    bus(16'hEF3F, 1'b1, 8'h0A);   // page1 = A
    bus(16'h0800, 1'b0, 8'h00);   // R1 just above carve-out
    bus(16'h07FF, 1'b1, 8'h11);   // R3 top of carve-out
    bus(16'h0000, 1'b0, 8'h00);   // R3
    bus(16'h8000, 1'b1, 8'h22);   // R2
    bus(16'hEEFF, 1'b0, 8'h00);   // R2 just below I/O
    bus(16'hFFFC, 1'b1, 8'h03);   // R4 write to vector area
    bus(16'hF000, 1'b1, 8'h07);   // R4 ROM base
    bus(16'hEF40, 1'b1, 8'h0C);   // R5 SPI sub-select, no page change
    bus(16'hEF60, 1'b1, 8'h0D);   // output byte
    bus(16'hEF80, 1'b0, 8'h00);   // input byte
    bus(16'hEFE0, 1'b1, 8'h0E);   // spare sub-select
    bus(16'h7FFF, 1'b0, 8'h00);   // R1
    chk("R4", "page0 untouched", 32'(m_p0), 32'h5);

    for (int i = 0; i < 400; i++) begin
      logic [15:0] a;
      a = 16'($urandom);
      if ($urandom % 3 == 0) a = {8'hEF, 3'($urandom % 3), 5'($urandom)};
      bus(a, 1'($urandom), 8'($urandom));
    end

    do_reset();
    cpu_addr = 16'h9ABC; #1 chk("R8", "mid-run reset ram_addr", 32'(ram_addr), 32'h01ABC);
    cpu_addr = 16'hEF20; #1 chk("R8", "mid-run reset page1", 32'(cpu_rdata), 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule